// File: doc/BRIEF.md
# Transmit Fail-Safe Watchdog

This block guards the transmit side of a serial remote terminal against a runaway message. It runs from a 12 MHz reference clock and counts cycles while the transmit-active input is high. When one message has been active for the equivalent of 768 µs (9216 clock cycles), it issues a one-cycle abort pulse that stops the encoder and sets a sticky fail-safe flag. The count returns to zero whenever transmit-active drops, so every message gets the full window.

The block also qualifies the start of a transmit cycle. While the active-low encoder enable is held low, a high-to-low transition of the encoder timing strobe produces a one-cycle start pulse, unless the fail-safe flag is set. The flag stays set after the message ends. It is cleared only by a fresh assertion of encoder enable (a high-to-low edge on the active-low pin) or by the synchronous master reset.

Top module: `txfs_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, `fail_safe`, `tx_abort` and `tx_start` are low after that edge.
- R2: With `enc_en_n` low, when `enc_strobe` is sampled high at one edge and low at the next, `tx_start` is high for exactly the one cycle after the second edge.
- R3: A falling edge of `enc_strobe` while `enc_en_n` is high produces no `tx_start` pulse.
- R4: When `tx_active` is sampled high on 9216 consecutive edges (768 µs at 12 MHz), `tx_abort` and `fail_safe` are high after the 9216th edge.
- R5: A message with `tx_active` sampled high on only 9215 consecutive edges raises neither `tx_abort` nor `fail_safe`.
- R6: The elapsed count restarts at zero after any edge where `tx_active` is low, so two 9000-edge messages separated by one low edge raise no abort.
- R7: `tx_abort` is a single-cycle pulse, and no further abort occurs while `fail_safe` stays set, even when `tx_active` remains high.
- R8: `fail_safe` stays high after `tx_active` falls, until a clear event.
- R9: While `fail_safe` is high, a strobe falling edge with `enc_en_n` low produces no `tx_start`.
- R10: A high-to-low edge on `enc_en_n` clears `fail_safe` after the edge that detects it.
- R11: The master reset `rst` clears a set `fail_safe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz reference clock |
| rst | input | 1 | Synchronous active-high master reset |
| enc_en_n | input | 1 | Encoder enable, active low |
| enc_strobe | input | 1 | Encoder timing strobe; its falling edge starts a transmit cycle |
| tx_active | input | 1 | High while transmit data is being shifted out |
| tx_start | output | 1 | One-cycle pulse marking the start of a transmit cycle |
| tx_abort | output | 1 | One-cycle pulse terminating an overlong message |
| fail_safe | output | 1 | Sticky flag set by a message-length timeout |

## Verification
Messages of 9215 edges, of 9216 edges and longer, and two long messages separated by one idle cycle are driven. They separate an off-by-one limit, a counter that does not restart, and a correct threshold. Strobe falling edges are applied with enable inactive, with enable active, and with the flag set, which shows that start qualification looks at both gates. The flag is cleared once by an enable re-assertion and once by master reset, each after it has been shown to persist past the end of the message.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

  function automatic int unsigned limit_cycles(input int unsigned clk_hz,
                                               input int unsigned limit_us);
    return (clk_hz / 1000000) * limit_us;
  endfunction

  localparam int unsigned EDGE_STROBE = 0;
  localparam int unsigned EDGE_ENABLE = 1;
  localparam int unsigned EDGE_COUNT  = 2;

endpackage

// File: rtl/txfs_fall_det.sv
module txfs_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_in;
  end

  assign fall = prev_q & ~sig_in;

endmodule

// File: rtl/txfs_msg_timer.sv
module txfs_msg_timer #(
  parameter int unsigned LIMIT = 9216,
  parameter int unsigned CW    = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = run && (cnt_q == LAST);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/txfs_flag_ctl.sv
module txfs_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic en_active,
  input  logic strobe_fall,
  output logic fail_safe,
  output logic tx_abort,
  output logic tx_start
);

  logic fs_q, abort_q, start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q    <= 1'b0;
      abort_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (set_evt)      fs_q <= 1'b1;
      else if (clr_evt) fs_q <= 1'b0;
      abort_q <= set_evt;
      start_q <= en_active && strobe_fall && !fs_q;
    end
  end

  assign fail_safe = fs_q;
  assign tx_abort  = abort_q;
  assign tx_start  = start_q;

  AST_ABORT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort); // R7
  AST_ABORT_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> fail_safe); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_safe && !clr_evt) |=> fail_safe); // R8
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !set_evt) |=> !fail_safe); // R10
  AST_NO_START_FAILED: assert property (@(posedge clk) disable iff (rst)
    fail_safe |=> !tx_start); // R9

endmodule

// File: rtl/txfs_watchdog.sv
module txfs_watchdog #(
  parameter int unsigned CLK_HZ   = 12000000,
  parameter int unsigned LIMIT_US = 768
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_en_n,
  input  logic enc_strobe,
  input  logic tx_active,
  output logic tx_start,
  output logic tx_abort,
  output logic fail_safe
);
  import txfs_pkg::*;

  localparam int unsigned LIMIT = limit_cycles(CLK_HZ, LIMIT_US);
  localparam int unsigned CW    = $clog2(LIMIT);

  logic [EDGE_COUNT-1:0] edge_in;
  logic [EDGE_COUNT-1:0] edge_fall;
  logic                  timer_hit;

  assign edge_in[EDGE_STROBE] = enc_strobe;
  assign edge_in[EDGE_ENABLE] = enc_en_n;

  for (genvar g = 0; g < EDGE_COUNT; g++) begin : g_fall
    txfs_fall_det u_fall (
      .clk    (clk),
      .rst    (rst),
      .sig_in (edge_in[g]),
      .fall   (edge_fall[g])
    );
  end

  txfs_msg_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (tx_active && !fail_safe),
    .hit (timer_hit)
  );

  txfs_flag_ctl u_flag (
    .clk         (clk),
    .rst         (rst),
    .set_evt     (timer_hit),
    .clr_evt     (edge_fall[EDGE_ENABLE]),
    .en_active   (!enc_en_n),
    .strobe_fall (edge_fall[EDGE_STROBE]),
    .fail_safe   (fail_safe),
    .tx_abort    (tx_abort),
    .tx_start    (tx_start)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!fail_safe && !tx_abort && !tx_start)); // R1

endmodule

// File: tb/txfs_watchdog_tb_top.sv
module txfs_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 9216;
  localparam int EV_START   = 0;
  localparam int EV_ABORT   = 1;

  typedef struct {
    int kind;
    int cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_en_n = 1'b1;
  logic enc_strobe = 1'b1;
  logic tx_active = 1'b0;
  logic tx_start, tx_abort, fail_safe;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int n_start = 0;
  int n_abort = 0;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txfs_watchdog dut_i (
    .clk(clk), .rst(rst), .enc_en_n(enc_en_n), .enc_strobe(enc_strobe),
    .tx_active(tx_active), .tx_start(tx_start), .tx_abort(tx_abort),
    .fail_safe(fail_safe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int kind, input int at);
    exp_t e;
    e.kind = kind;
    e.cyc  = at;
    expq.push_back(e);
  endtask

  task automatic observe(input int kind);
    string req;
    exp_t e;
    req = (kind == EV_START) ? "R2" : "R4";
    if (expq.size() == 0) begin
      chk(1'b0, req, cyc, -1);
    end else begin
      e = expq.pop_front();
      chk(e.kind == kind && e.cyc == cyc, req, cyc, e.cyc);
    end
  endtask

  // monitor: pops expected events as the outputs pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_start) begin n_start++; observe(EV_START); end
      if (tx_abort) begin n_abort++; observe(EV_ABORT); end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    chk(!fail_safe && !tx_abort && !tx_start, "R1", fail_safe, 0);
    rst = 1'b0;
    tick(2);

    // R3: strobe fall with enable inactive
    enc_strobe = 1'b0; tick(3);
    enc_strobe = 1'b1; tick(2);
    chk(n_start == 0, "R3", n_start, 0);

    // R2: qualified start
    enc_en_n = 1'b0; tick(2);
    push(EV_START, cyc + 1);
    enc_strobe = 1'b0; tick(3);
    enc_strobe = 1'b1; tick(2);
    chk(n_start == 1, "R2", n_start, 1);

    // R5: one edge short of the limit
    tx_active = 1'b1; tick(LIMIT - 1);
    tx_active = 1'b0; tick(3);
    chk(!fail_safe, "R5", fail_safe, 0);
    chk(n_abort == 0, "R5", n_abort, 0);

    // R6: count restarts between messages
    tx_active = 1'b1; tick(9000);
    tx_active = 1'b0; tick(1);
    tx_active = 1'b1; tick(9000);
    tx_active = 1'b0; tick(3);
    chk(n_abort == 0 && !fail_safe, "R6", n_abort, 0);

    // R4: exactly at the limit
    push(EV_ABORT, cyc + LIMIT);
    tx_active = 1'b1; tick(LIMIT);
    chk(fail_safe, "R4", fail_safe, 1);
    tick(200);
    chk(n_abort == 1, "R7", n_abort, 1);
    tx_active = 1'b0; tick(5);
    chk(fail_safe, "R8", fail_safe, 1);

    // R9: start blocked while flag is set
    enc_strobe = 1'b0; tick(3);
    enc_strobe = 1'b1; tick(2);
    chk(n_start == 1, "R9", n_start, 1);

    // R10: enable re-assertion clears flag
    enc_en_n = 1'b1; tick(2);
    enc_en_n = 1'b0; tick(2);
    chk(!fail_safe, "R10", fail_safe, 0);
    push(EV_START, cyc + 1);
    enc_strobe = 1'b0; tick(3);
    enc_strobe = 1'b1; tick(2);
    chk(n_start == 2, "R2", n_start, 2);

    // R11: master reset clears flag
    push(EV_ABORT, cyc + LIMIT);
    tx_active = 1'b1; tick(LIMIT + 4);
    tx_active = 1'b0; tick(2);
    chk(fail_safe, "R8", fail_safe, 1);
    rst = 1'b1; tick(2);
    chk(!fail_safe, "R11", fail_safe, 0);
    rst = 1'b0; tick(3);
    chk(!fail_safe, "R11", fail_safe, 0);

    chk(expq.size() == 0, "R4", expq.size(), 0);
    summary();
  end

endmodule